// File: doc/BRIEF.md
# Register-Controlled SPI Master (Mode 0, Single Select)

This block is an SPI master with one chip select. Software controls it through five 32-bit registers on a simple bus with address, write enable, write data and read data. It first writes the configuration register, which sets the word width (8 or 16 bits) and the serial clock divisor. It then asserts the chip select through a control bit. Writing the transmit register sends one word. The block shifts that word out MSB first on the data output and captures the same number of bits from the data input. When the word is done, it sets a completion flag that software clears by writing the cause register.

Only SPI mode 0 is supported: the serial clock idles low, input data is sampled on the rising edge, and output data changes on the falling edge.

The clock divisor is a 5-bit code. The serial clock period is `2*(code-16)` system clocks. Legal codes run from 18 to 31, which gives even ratios from 4 to 30. A code below 18 is treated as ratio 4. The word width and the divisor are taken when a word starts, so a configuration write during a word does not affect that word.

Top module: `spi_mm_master`

## Requirements
- R1: Register map at byte addresses: 0x00 control, 0x04 configuration, 0x08 transmit, 0x0C receive, 0x10 cause. Configuration reads back all 32 bits as written, and only bit 5 (width, 1 = 16-bit) and bits [4:0] (divisor code) have any effect. Unmapped addresses read zero.
- R2: `csN` is the inverse of control bit 0. It is low one clock after a write with bit 0 set and high one clock after a write with bit 0 clear. Control reads back bit 0 only.
- R3: During a word, SCK stays high for `ratio/2` clocks and low for `ratio/2` clocks. The ratio is `2*(code-16)` for codes 18 to 31, and 4 for any code below 18.
- R4: A transmit write while idle starts one word. The cause register reads 1 exactly `bits*ratio` clocks after the write edge, where bits is 8 or 16.
- R5: SCK is low whenever no word is in progress. MOSI does not change while SCK is high. MISO is captured on the rising SCK edges.
- R6: 8-bit mode sends transmit bits [7:0] MSB first. The received byte reads in receive bits [7:0], and bits [31:8] read zero.
- R7: 16-bit mode sends transmit bits [15:0] MSB first. The received word reads in receive bits [15:0].
- R8: Any write to the cause register clears the flag. A completion in the same cycle takes precedence over the clear.
- R9: A transmit write while a word is in progress is ignored. The word in flight, the transmit register contents and the bits sent are unchanged.
- R10: After reset, `csN` is high, SCK and MOSI are low, and every register reads zero.
- R11: The receive register keeps its value until the next word completes, including during that next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |

## Verification
The assertions assume the following about the inputs:
- The bus presents byte addresses that are multiples of four.
- A write lasts exactly one clock.
- MISO changes only away from the rising SCK edge, as a mode-0 slave drives it.

The stimulus keeps within these limits by driving the bus at the falling system clock edge. The bench slave updates MISO only on falling SCK edges and only a clock or more after a rising edge.

The random part of the stimulus draws legal divisor codes, widths and data words. The directed part adds codes below 18, writes during a word, and a configuration change between words.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int MAX_BITS = 16;
  localparam int CODE_W = 5;
  localparam int HALF_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE = 5'h10;

  localparam int WIDE_BIT = 5;
  localparam logic [CODE_W-1:0] CODE_MIN = 5'h12;
  localparam logic [CODE_W-1:0] CODE_BASE = 5'h10;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // word accepted, load shifter
    logic sample;  // rising SCK: capture miso
    logic shift;   // falling SCK: advance shifter
    logic finish;  // last falling SCK: publish result
  } spiStrobe_t;
endpackage

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txReq,
  input  logic              cfgWide,
  input  logic [CODE_W-1:0] cfgCode,
  output spiStrobe_t        stb,
  output logic              sck,
  output logic              busy,
  output logic              wideQ
);
  localparam int CNT_W = $clog2(MAX_BITS);

  logic [HALF_W-1:0] halfSel;
  logic [HALF_W-1:0] halfQ;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              tick;
  logic [CODE_W-1:0] codeOff;

  assign codeOff = cfgCode - CODE_BASE;
  assign halfSel = (cfgCode < CODE_MIN) ? HALF_W'(2) : codeOff[HALF_W-1:0];
  assign tick    = busy && (halfCnt == '0);

  always_comb begin
    stb        = '0;
    stb.load   = txReq && !busy;
    stb.sample = tick && !sck;
    stb.shift  = tick && sck && (bitCnt != '0);
    stb.finish = tick && sck && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      wideQ   <= 1'b0;
      halfQ   <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      wideQ   <= cfgWide;
      halfQ   <= halfSel;
      halfCnt <= halfSel - HALF_W'(1);
      bitCnt  <= cfgWide ? CNT_W'(MAX_BITS - 1) : CNT_W'(MAX_BITS/2 - 1);
    end else if (busy) begin
      if (tick) begin
        halfCnt <= halfQ - HALF_W'(1);
        sck     <= !sck;
        if (stb.finish) busy <= 1'b0;
        if (stb.shift) bitCnt <= bitCnt - CNT_W'(1);
      end else begin
        halfCnt <= halfCnt - HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_mm_dp.sv
module spi_mm_dp
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  spiStrobe_t        stb,
  input  logic              busy,
  input  logic              wideQ,
  input  logic              miso,
  output logic              mosi,
  output logic              csN,
  output logic              txReq,
  output logic              cfgWide,
  output logic [CODE_W-1:0] cfgCode,
  output logic              causeFlag,
  output logic [MAX_BITS-1:0] txHold
);
  logic                csBit;
  logic [DATA_W-1:0]   cfgReg;
  logic [MAX_BITS-1:0] rxData;
  logic [MAX_BITS-1:0] shReg;
  logic [MAX_BITS-1:0] shNext;
  logic                rxBit;

  assign txReq   = busWe && (busAddr == ADDR_TX);
  assign cfgWide = cfgReg[WIDE_BIT];
  assign cfgCode = cfgReg[CODE_W-1:0];
  assign csN     = !csBit;
  assign shNext  = {shReg[MAX_BITS-2:0], rxBit};
  assign mosi    = busy && (wideQ ? shReg[MAX_BITS-1] : shReg[MAX_BITS/2-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csBit     <= 1'b0;
      cfgReg    <= '0;
      txHold    <= '0;
      rxData    <= '0;
      shReg     <= '0;
      rxBit     <= 1'b0;
      causeFlag <= 1'b0;
    end else begin
      if (busWe && busAddr == ADDR_CTRL) csBit <= busWdata[0];
      if (busWe && busAddr == ADDR_CFG) cfgReg <= busWdata;
      if (stb.load) begin
        txHold <= busWdata[MAX_BITS-1:0];
        shReg  <= busWdata[MAX_BITS-1:0];
      end
      if (stb.sample) rxBit <= miso;
      if (stb.shift) shReg <= shNext;
      if (stb.finish) begin
        rxData <= wideQ ? shNext : {{(MAX_BITS/2){1'b0}}, shNext[MAX_BITS/2-1:0]};
        causeFlag <= 1'b1;
      end else if (busWe && busAddr == ADDR_CAUSE) begin
        causeFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL:  busRdata = {{(DATA_W-1){1'b0}}, csBit};
      ADDR_CFG:   busRdata = cfgReg;
      ADDR_TX:    busRdata = {{(DATA_W-MAX_BITS){1'b0}}, txHold};
      ADDR_RX:    busRdata = {{(DATA_W-MAX_BITS){1'b0}}, rxData};
      ADDR_CAUSE: busRdata = {{(DATA_W-1){1'b0}}, causeFlag};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  spiStrobe_t          stb;
  logic                busy;
  logic                wideQ;
  logic                txReq;
  logic                cfgWide;
  logic [CODE_W-1:0]   cfgCode;
  logic                causeFlag;
  logic [MAX_BITS-1:0] txHold;

  spi_mm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txReq(txReq), .cfgWide(cfgWide),
    .cfgCode(cfgCode), .stb(stb), .sck(sck), .busy(busy), .wideQ(wideQ)
  );

  spi_mm_dp u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .stb(stb), .busy(busy),
    .wideQ(wideQ), .miso(miso), .mosi(mosi), .csN(csN), .txReq(txReq),
    .cfgWide(cfgWide), .cfgCode(cfgCode), .causeFlag(causeFlag),
    .txHold(txHold)
  );
endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker
  import spi_mm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic              sck,
  input logic              mosi,
  input logic              csN,
  input logic              busy,
  input logic              causeFlag,
  input logic              finishStb,
  input logic [MAX_BITS-1:0] txHold
);
  // R5: serial clock low outside a word
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  // R5: output data holds while the serial clock is high
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R2: chip select follows the control write
  p_cs_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CTRL) |=> (csN == !$past(busWdata[0])));

  // R4: end of a word raises the cause flag
  p_cause_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> causeFlag);

  // R8: a clear without a concurrent completion drops the flag
  p_cause_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CAUSE && !finishStb) |=> !causeFlag);

  // R9: transmit writes during a word leave the held word alone
  p_tx_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWe && busAddr == ADDR_TX) |=> $stable(txHold));
endmodule

bind spi_mm_master spi_mm_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .sck(sck), .mosi(mosi), .csN(csN), .busy(busy),
  .causeFlag(causeFlag), .finishStb(stb.finish), .txHold(txHold)
);

// File: tb/tb_spi_mm_master.sv
module tb_spi_mm_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi, miso, csN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mm_master dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  // mode-0 slave model
  logic [15:0] slaveWord = '0;
  logic [15:0] slaveRx = '0;
  logic        slaveWide = 1'b0;
  int          slaveIdx = 0;
  int          riseCyc = 0;
  int          highLen = 0;
  int          lowLen = 0;
  int          fallCyc = 0;

  function automatic logic slaveBit(logic [15:0] w, logic wide, int idx);
    int n = wide ? 16 : 8;
    if (idx >= n) return 1'b0;
    return w[n-1-idx];
  endfunction

  assign miso = slaveBit(slaveWord, slaveWide, slaveIdx);

  always @(posedge sck) begin
    slaveRx = {slaveRx[14:0], mosi};
    riseCyc = cyc;
    if (fallCyc != 0) lowLen = cyc - fallCyc;
  end
  always @(negedge sck) begin
    slaveIdx = slaveIdx + 1;
    highLen = cyc - riseCyc;
    fallCyc = cyc;
  end

  function automatic int expRatio(int code);
    return (code < 18) ? 4 : 2 * (code - 16);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic xfer(int code, logic wide, logic [15:0] tx, logic [15:0] sw,
                      logic midWrite);
    logic [31:0] v;
    int n, cnt, ratio;
    logic [15:0] m;
    n = wide ? 16 : 8;
    m = wide ? 16'hFFFF : 16'h00FF;
    ratio = expRatio(code);
    wr(5'h04, {26'h0, wide, code[4:0]});
    wr(5'h10, 32'h0);
    slaveWord = sw; slaveWide = wide; slaveIdx = 0; slaveRx = '0;
    highLen = 0; lowLen = 0; fallCyc = 0;
    wr(5'h08, {16'h0, tx});
    cnt = 0;
    if (midWrite) begin
      busAddr = 5'h08; busWdata = 32'h0000_A5C3; busWe = 1'b1;
      @(negedge clk); busWe = 1'b0; cnt = 1;
      rd(5'h08, v);
      check("R9 tx hold", v, {16'h0, tx});
    end
    forever begin
      rd(5'h10, v);
      if (v[0] || cnt > 1000) break;
      @(negedge clk); cnt++;
    end
    check("R4 duration", cnt, n * ratio);
    check("R3 sck high", highLen, ratio / 2);
    check("R3 sck low", lowLen, ratio / 2);
    check(wide ? "R7 mosi bits" : "R6 mosi bits", {16'h0, slaveRx & m}, {16'h0, tx & m});
    rd(5'h0C, v);
    check(wide ? "R7 rx word" : "R6 rx word", v, {16'h0, sw & m});
    check("R5 sck idle", {31'h0, sck}, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] oldRx;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 csN", {31'h0, csN}, 32'h1);
    check("R10 sck", {31'h0, sck}, 32'h0);
    check("R10 mosi", {31'h0, mosi}, 32'h0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(a[4:0], v);
      check("R10 reg zero", v, 32'h0);
    end
    rstN = 1'b1;
    @(negedge clk);
    // R1 register readback
    wr(5'h04, 32'hDEAD_BE35);
    rd(5'h04, v); check("R1 cfg readback", v, 32'hDEAD_BE35);
    rd(5'h14, v); check("R1 unmapped", v, 32'h0);
    // R2 chip select
    wr(5'h00, 32'hFFFF_FFF1);
    check("R2 cs asserted", {31'h0, csN}, 32'h0);
    rd(5'h00, v); check("R2 ctrl readback", v, 32'h1);
    // directed: lowest code, code below legal range, top code
    xfer(18, 1'b0, 16'h00A5, 16'h003C, 1'b0);
    xfer(0, 1'b0, 16'h0081, 16'h00FF, 1'b0);
    xfer(17, 1'b1, 16'h8001, 16'h7FFE, 1'b0);
    xfer(31, 1'b1, 16'hF00F, 16'h1234, 1'b0);
    // R8 cause clear
    wr(5'h10, 32'h0);
    rd(5'h10, v); check("R8 cause cleared", v, 32'h0);
    // R9 write during a word
    xfer(20, 1'b1, 16'h5AA5, 16'hC3C3, 1'b1);
    // R11 hold across config change and during next word
    rd(5'h0C, v); oldRx = v[15:0];
    wr(5'h04, 32'h0000_0033);
    rd(5'h0C, v); check("R11 rx hold cfg", v, {16'h0, oldRx});
    wr(5'h10, 32'h0);
    slaveIdx = 0;
    wr(5'h08, 32'h0000_1111);
    repeat (10) @(negedge clk);
    rd(5'h0C, v); check("R11 rx hold busy", v, {16'h0, oldRx});
    forever begin
      rd(5'h10, v);
      if (v[0]) break;
      @(negedge clk);
    end
    // random words
    for (int i = 0; i < 24; i++) begin
      int c = 18 + ($urandom % 14);
      xfer(c, 1'($urandom % 2), 16'($urandom), 16'($urandom), 1'b0);
    end
    wr(5'h00, 32'h0);
    check("R2 cs released", {31'h0, csN}, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule